// File: doc/BRIEF.md
# Software-Refilled Fully Associative Translation Buffer

This block turns a 32-bit virtual address into a physical address for a processor pipeline. It stores a set of page translations, each tagged with an address-space identifier. Every stored entry is compared with the incoming page number and identifier in the same cycle. The top three address bits pick a segment first. Two kernel segments skip translation and map straight onto physical memory. The other segments are translated through the buffer.

Software owns the contents. A handler loads any entry, chosen by index, through a write port. The block never walks page tables. When a lookup finds no usable entry, it raises a fault flag so the handler can refill an entry and retry. It also reports stores that break an entry's write permission, and stores to a page that is not yet marked modified. Every response is registered and appears one cycle after its request.

Top module: `xlat_buffer`

## Requirements
- R1: A response appears exactly one cycle after its request. `rspValid` is high in cycle t+1 only if `reqValid` was high in cycle t. While `rspValid` is low, every response output is zero.
- R2: For a translated segment (bit 31 = 0, or bits [31:30] = 11), an entry hits when its page number equals address bits [31:12] and its identifier equals `reqAsid`. A hit on a valid entry, with no fault, gives `rspPaddr` = {entry frame, address bits [11:0]}.
- R3: When bits [31:29] = 100, no lookup takes place. `rspPaddr` is the address with bits [31:29] cleared, `rspCacheable` = 1, no fault flag is raised, `rspMultiHit` = 0, and `rspHitIdx`, `rspDirty` and `rspRef` are 0. A store is treated the same way.
- R4: When bits [31:29] = 101, the address maps as in R3, but `rspCacheable` = 0.
- R5: A translated lookup that matches no entry raises `rspMiss`. In that case `rspPaddr`, `rspCacheable`, `rspHitIdx`, `rspDirty` and `rspRef` are all 0. No more than one of `rspMiss`, `rspProtFault` and `rspModFault` is ever high, and `rspPaddr` is 0 whenever any of them is high.
- R6: A match on an entry whose valid bit is 0 raises `rspMiss`, whether or not the request is a store.
- R7: A store that matches a valid entry whose writable bit is 0 raises `rspProtFault` and gives no translation. A load to the same entry translates normally.
- R8: A store that matches a valid, writable entry whose dirty bit is 0 raises `rspModFault`. When the dirty bit is 1, the store translates normally.
- R9: When `wrEn` is high, the entry at `wrIdx` takes all of the write fields in one cycle. A lookup made in the same cycle uses the entry's old contents.
- R10: When several entries match, the lowest index is used for the result and `rspMultiHit` = 1.
- R11: Entries with the same page number but different identifiers are independent. A lookup only uses the entries that carry its own identifier.
- R12: On a match, `rspHitIdx`, `rspDirty` and `rspRef` report the index, dirty bit and referenced bit of the chosen entry, even when a fault is raised. On a hit with no fault, `rspCacheable` is that entry's cacheable bit.
- R13: Reset clears every entry to all-zero fields (valid = 0), and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request |
| reqAddr | input | 32 | Virtual address |
| reqAsid | input | 6 | Address-space identifier of the request |
| reqStore | input | 1 | Request is a store |
| wrEn | input | 1 | Load an entry |
| wrIdx | input | 6 | Index of the entry to load |
| wrVpn | input | 20 | Virtual page number for the entry |
| wrAsid | input | 6 | Identifier for the entry |
| wrPfn | input | 20 | Physical frame number for the entry |
| wrDirty | input | 1 | Dirty (modified) bit |
| wrRef | input | 1 | Referenced bit |
| wrValid | input | 1 | Valid bit |
| wrWritable | input | 1 | Write permission |
| wrCacheable | input | 1 | Page may be cached |
| rspValid | output | 1 | Response valid |
| rspPaddr | output | 32 | Physical address |
| rspCacheable | output | 1 | Access may be cached |
| rspMiss | output | 1 | Translation fault: no match, or the matched entry is invalid |
| rspProtFault | output | 1 | Store to a read-only page |
| rspModFault | output | 1 | First store to a clean page |
| rspMultiHit | output | 1 | More than one entry matched |
| rspHitIdx | output | 6 | Index of the chosen entry |
| rspDirty | output | 1 | Dirty bit of the chosen entry |
| rspRef | output | 1 | Referenced bit of the chosen entry |

## Verification
The two functions that can fall in the same cycle are a software refill and a lookup of the page being refilled. The bench drives `wrEn` together with a request for the very page number and identifier that the write installs. The request must come back as a miss, because it reads the old contents. The following request must then hit, with the new frame. A behavioural reference model updates its own entry table only after it has computed the expected response, and the bench compares every output against that model on every clock.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = 20;
  localparam int ASID_W = 6;
  localparam int SEG_W  = 3;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PFN_W-1:0]  pfn;
    logic              dirty;
    logic              refd;
    logic              valid;
    logic              writable;
    logic              cacheable;
  } tlbEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic lookup;
    logic isStore;
    logic bypass;
    logic bypassCache;
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    SEG_MAPPED  = 2'd0,
    SEG_PHYS_C  = 2'd1,
    SEG_PHYS_NC = 2'd2
  } segKind_e;
endpackage

// File: rtl/xlat_datapath.sv
module xlat_datapath
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  tlbEntry_t         wrEntry,
  input  ctlStrobe_t        ctl,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [ASID_W-1:0] lkAsid,
  output logic              anyMatch,
  output logic              multiMatch,
  output logic [IDX_W-1:0]  pickIdx,
  output tlbEntry_t         pickEntry
);
  tlbEntry_t entMem [ENTRIES];
  logic [ENTRIES-1:0] matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) entMem[i] <= '0;
    end else if (wrEn) begin
      entMem[wrIdx] <= wrEntry;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign matchVec[g] = ctl.lookup && (entMem[g].vpn == lkVpn) && (entMem[g].asid == lkAsid);
  end

  always_comb begin
    pickIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) pickIdx = IDX_W'(i);
    end
  end

  assign anyMatch   = |matchVec;
  assign multiMatch = |(matchVec & (matchVec - ENTRIES'(1)));
  assign pickEntry  = anyMatch ? entMem[pickIdx] : '0;

  // R9
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> entMem[$past(wrIdx)] == $past(wrEntry));

  // R10
  multi_has_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    multiMatch |-> anyMatch && ctl.lookup);
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqAddr,
  input  logic              reqStore,
  output ctlStrobe_t        ctl,
  input  logic              anyMatch,
  input  logic              multiMatch,
  input  logic [IDX_W-1:0]  pickIdx,
  input  tlbEntry_t         pickEntry,
  output logic              rspValid,
  output logic [VA_W-1:0]   rspPaddr,
  output logic              rspCacheable,
  output logic              rspMiss,
  output logic              rspProtFault,
  output logic              rspModFault,
  output logic              rspMultiHit,
  output logic [IDX_W-1:0]  rspHitIdx,
  output logic              rspDirty,
  output logic              rspRef
);
  segKind_e segKind;
  logic [SEG_W-1:0] segBits;

  assign segBits = reqAddr[VA_W-1 -: SEG_W];

  always_comb begin
    unique case (segBits)
      3'b100:  segKind = SEG_PHYS_C;
      3'b101:  segKind = SEG_PHYS_NC;
      default: segKind = SEG_MAPPED;
    endcase
  end

  always_comb begin
    ctl.lookup      = reqValid && (segKind == SEG_MAPPED);
    ctl.isStore     = reqValid && reqStore;
    ctl.bypass      = reqValid && (segKind != SEG_MAPPED);
    ctl.bypassCache = segKind == SEG_PHYS_C;
  end

  logic             nMiss, nProt, nMod, nCache, nMulti, nDirty, nRef;
  logic [VA_W-1:0]  nPaddr;
  logic [IDX_W-1:0] nIdx;

  always_comb begin
    nMiss = 1'b0; nProt = 1'b0; nMod = 1'b0; nCache = 1'b0;
    nMulti = 1'b0; nDirty = 1'b0; nRef = 1'b0;
    nPaddr = '0; nIdx = '0;
    if (ctl.bypass) begin
      nPaddr = {{SEG_W{1'b0}}, reqAddr[VA_W-SEG_W-1:0]};
      nCache = ctl.bypassCache;
    end else if (ctl.lookup) begin
      nMulti = multiMatch;
      if (anyMatch) begin
        nIdx   = pickIdx;
        nDirty = pickEntry.dirty;
        nRef   = pickEntry.refd;
      end
      if (!anyMatch || !pickEntry.valid) begin
        nMiss = 1'b1;
      end else if (ctl.isStore && !pickEntry.writable) begin
        nProt = 1'b1;
      end else if (ctl.isStore && !pickEntry.dirty) begin
        nMod = 1'b1;
      end else begin
        nPaddr = {pickEntry.pfn, reqAddr[OFF_W-1:0]};
        nCache = pickEntry.cacheable;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0; rspPaddr <= '0; rspCacheable <= 1'b0;
      rspMiss <= 1'b0; rspProtFault <= 1'b0; rspModFault <= 1'b0;
      rspMultiHit <= 1'b0; rspHitIdx <= '0; rspDirty <= 1'b0; rspRef <= 1'b0;
    end else begin
      rspValid <= reqValid; rspPaddr <= nPaddr; rspCacheable <= nCache;
      rspMiss <= nMiss; rspProtFault <= nProt; rspModFault <= nMod;
      rspMultiHit <= nMulti; rspHitIdx <= nIdx; rspDirty <= nDirty; rspRef <= nRef;
    end
  end

  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid && rspPaddr == '0 && !rspMiss && !rspMultiHit);
  // R3
  bypass_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[VA_W-1 -: 2] == 2'b10) |=>
      !rspMiss && !rspProtFault && !rspModFault && !rspMultiHit &&
      rspPaddr[VA_W-1 -: SEG_W] == '0);
  // R5
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rspMiss, rspProtFault, rspModFault}) <= 1);
  // R5
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspMiss || rspProtFault || rspModFault) |-> rspPaddr == '0 && !rspCacheable);
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic [5:0]        reqAsid,
  input  logic              reqStore,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [19:0]       wrVpn,
  input  logic [5:0]        wrAsid,
  input  logic [19:0]       wrPfn,
  input  logic              wrDirty,
  input  logic              wrRef,
  input  logic              wrValid,
  input  logic              wrWritable,
  input  logic              wrCacheable,
  output logic              rspValid,
  output logic [31:0]       rspPaddr,
  output logic              rspCacheable,
  output logic              rspMiss,
  output logic              rspProtFault,
  output logic              rspModFault,
  output logic              rspMultiHit,
  output logic [IDX_W-1:0]  rspHitIdx,
  output logic              rspDirty,
  output logic              rspRef
);
  ctlStrobe_t       ctl;
  tlbEntry_t        wrEntry, pickEntry;
  logic             anyMatch, multiMatch;
  logic [IDX_W-1:0] pickIdx;

  always_comb begin
    wrEntry.vpn       = wrVpn;
    wrEntry.asid      = wrAsid;
    wrEntry.pfn       = wrPfn;
    wrEntry.dirty     = wrDirty;
    wrEntry.refd      = wrRef;
    wrEntry.valid     = wrValid;
    wrEntry.writable  = wrWritable;
    wrEntry.cacheable = wrCacheable;
  end

  xlat_datapath #(.ENTRIES(ENTRIES)) i_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrEntry(wrEntry),
    .ctl(ctl), .lkVpn(reqAddr[VA_W-1:OFF_W]), .lkAsid(reqAsid),
    .anyMatch(anyMatch), .multiMatch(multiMatch), .pickIdx(pickIdx), .pickEntry(pickEntry)
  );

  xlat_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqStore(reqStore),
    .ctl(ctl), .anyMatch(anyMatch), .multiMatch(multiMatch), .pickIdx(pickIdx),
    .pickEntry(pickEntry), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspCacheable(rspCacheable), .rspMiss(rspMiss), .rspProtFault(rspProtFault),
    .rspModFault(rspModFault), .rspMultiHit(rspMultiHit), .rspHitIdx(rspHitIdx),
    .rspDirty(rspDirty), .rspRef(rspRef)
  );
endmodule

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic reqValid = 0, reqStore = 0, wrEn = 0;
  logic [31:0] reqAddr = 0;
  logic [5:0] reqAsid = 0, wrIdx = 0, wrAsid = 0;
  logic [19:0] wrVpn = 0, wrPfn = 0;
  logic wrDirty = 0, wrRef = 0, wrValid = 0, wrWritable = 0, wrCacheable = 0;
  logic rspValid, rspCacheable, rspMiss, rspProtFault, rspModFault, rspMultiHit, rspDirty, rspRef;
  logic [31:0] rspPaddr;
  logic [5:0] rspHitIdx;

  xlat_buffer i_xlat_buffer (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model table
  int mVpn[64], mAsid[64], mPfn[64];
  bit mD[64], mR[64], mV[64], mW[64], mC[64];

  logic [31:0] ePaddr;
  logic [5:0] eIdx;
  bit eValid, eCache, eMiss, eProt, eMod, eMulti, eDirty, eRef;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "rspValid", 32'(rspValid), 32'(eValid));
    chk(tag, "rspPaddr", rspPaddr, ePaddr);
    chk(tag, "rspCacheable", 32'(rspCacheable), 32'(eCache));
    chk(tag, "rspMiss", 32'(rspMiss), 32'(eMiss));
    chk(tag, "rspProtFault", 32'(rspProtFault), 32'(eProt));
    chk(tag, "rspModFault", 32'(rspModFault), 32'(eMod));
    chk(tag, "rspMultiHit", 32'(rspMultiHit), 32'(eMulti));
    chk(tag, "rspHitIdx", 32'(rspHitIdx), 32'(eIdx));
    chk(tag, "rspDirty", 32'(rspDirty), 32'(eDirty));
    chk(tag, "rspRef", 32'(rspRef), 32'(eRef));
  endtask

  // expected response from the requirements, using the model table
  task automatic predict();
    int hits = 0, first = -1;
    ePaddr = 0; eIdx = 0; eValid = reqValid; eCache = 0; eMiss = 0; eProt = 0;
    eMod = 0; eMulti = 0; eDirty = 0; eRef = 0;
    if (!reqValid) return;
    if (reqAddr[31:29] == 3'b100 || reqAddr[31:29] == 3'b101) begin
      ePaddr = reqAddr & 32'h1FFF_FFFF;
      eCache = (reqAddr[29] == 1'b0);
      return;
    end
    for (int i = 0; i < 64; i++)
      if (mVpn[i] == int'(reqAddr[31:12]) && mAsid[i] == int'(reqAsid)) begin
        hits++;
        if (first < 0) first = i;
      end
    eMulti = hits > 1;
    if (first >= 0) begin
      eIdx = 6'(first); eDirty = mD[first]; eRef = mR[first];
    end
    if (first < 0 || !mV[first]) eMiss = 1;
    else if (reqStore && !mW[first]) eProt = 1;
    else if (reqStore && !mD[first]) eMod = 1;
    else begin
      ePaddr = {mPfn[first][19:0], reqAddr[11:0]};
      eCache = mC[first];
    end
  endtask

  // one clock: drive at negedge, predict from old table, then apply write
  task automatic step(string tag);
    predict();
    if (wrEn) begin
      mVpn[wrIdx] = int'(wrVpn); mAsid[wrIdx] = int'(wrAsid); mPfn[wrIdx] = int'(wrPfn);
      mD[wrIdx] = wrDirty; mR[wrIdx] = wrRef; mV[wrIdx] = wrValid;
      mW[wrIdx] = wrWritable; mC[wrIdx] = wrCacheable;
    end
    @(negedge clk);
    compareAll(tag);
    reqValid = 0; reqStore = 0; wrEn = 0;
  endtask

  task automatic setWrite(int idx, int vpn, int asid, int pfn, bit d, bit r, bit v, bit w, bit c);
    wrEn = 1; wrIdx = 6'(idx); wrVpn = 20'(vpn); wrAsid = 6'(asid); wrPfn = 20'(pfn);
    wrDirty = d; wrRef = r; wrValid = v; wrWritable = w; wrCacheable = c;
  endtask

  task automatic setReq(logic [31:0] a, int asid, bit st);
    reqValid = 1; reqAddr = a; reqAsid = 6'(asid); reqStore = st;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mVpn[i] = 0; mAsid[i] = 0; mPfn[i] = 0;
      mD[i] = 0; mR[i] = 0; mV[i] = 0; mW[i] = 0; mC[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    // R13 reset state
    step("R13");
    // R9 load an entry; R1 idle response
    setWrite(3, 'h12345, 5, 'hABCDE, 1, 1, 1, 1, 1); step("R9");
    // R2 user segment hit, load and store
    setReq(32'h1234_5678, 5, 0); step("R2");
    setReq(32'h1234_5FFF, 5, 1); step("R2");
    // R11 other identifier misses (R5)
    setReq(32'h1234_5678, 6, 0); step("R11");
    setWrite(10, 'h12345, 6, 'h11111, 0, 0, 1, 1, 0); step("R9");
    setReq(32'h1234_5001, 6, 0); step("R11");
    setReq(32'h1234_5001, 5, 0); step("R12");
    // R8 clean page store, then dirty
    setReq(32'h1234_5002, 6, 1); step("R8");
    setWrite(10, 'h12345, 6, 'h11111, 1, 1, 1, 1, 0); step("R9");
    setReq(32'h1234_5002, 6, 1); step("R8");
    // R7 kernel mapped, read-only
    setWrite(20, 'hE0001, 2, 'h0BEEF, 1, 0, 1, 0, 1); step("R9");
    setReq(32'hE000_1ABC, 2, 0); step("R7");
    setReq(32'hE000_1ABC, 2, 1); step("R7");
    // R6 invalid entry
    setWrite(21, 'h00042, 1, 'h00777, 1, 1, 0, 1, 1); step("R9");
    setReq(32'h0004_2010, 1, 0); step("R6");
    setReq(32'h0004_2010, 1, 1); step("R6");
    // R5 no match at all
    setReq(32'h7FFF_F000, 9, 1); step("R5");
    // R3 / R4 bypass segments, load and store
    setReq(32'h8123_4567, 0, 0); step("R3");
    setReq(32'h9FFF_FFFF, 7, 1); step("R3");
    setReq(32'hA765_4321, 0, 0); step("R4");
    setReq(32'hBFFF_F000, 3, 1); step("R4");
    // R10 two matches, lowest index wins
    setWrite(40, 'h55555, 3, 'h00040, 1, 1, 1, 1, 1); step("R9");
    setWrite(7, 'h55555, 3, 'h00007, 1, 0, 1, 1, 0); step("R9");
    setReq(32'h5555_5123, 3, 0); step("R10");
    setWrite(7, 'h55555, 3, 'h00007, 1, 0, 0, 1, 0); step("R9");
    setReq(32'h5555_5123, 3, 0); step("R10");
    // R9 write and lookup of the same page in one cycle
    setWrite(50, 'h66666, 4, 'h00ABC, 1, 1, 1, 1, 1);
    setReq(32'h6666_6004, 4, 0); step("R9");
    setReq(32'h6666_6004, 4, 0); step("R9");
    // R1 back-to-back requests then idle
    setReq(32'hE000_1000, 2, 0); step("R1");
    setReq(32'h8000_0010, 0, 0); step("R1");
    step("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule